// File: doc/BRIEF.md
# Threshold-Driven Audio Sample FIFO

This block buffers audio samples in both directions between a small memory-mapped register port and a serial audio engine. Software, or a DMA engine acting for it, writes playback samples to a single data address, which fills the transmit queue. The serializer drains that queue one sample at a time. Captured samples pushed by the deserializer collect in the receive queue and come back out through reads of the same data address.

Each direction has a fill threshold and a request enable, both held in one control word. From these the block drives a DMA request line per direction. The transmit request stays high while the queue has room for another burst. The receive request stays high while enough samples are waiting. The control word also carries self-clearing flush bits that empty either queue. A level register reports both fill counts. A sticky interrupt status register records transmit underflow and receive overflow until software clears the bits by writing ones.

Top module: `audio_smpl_fifo`

## Requirements
- R1: After reset the control word reads 0x00101000 (both thresholds 16, both request enables 0). The level register and the interrupt status read 0, and both request lines are low.
- R2: A bus write to register index 3 (data) pushes bus_wdata into the transmit queue. ser_tx_data shows the oldest entry whenever the queue is not empty, and each ser_tx_pop removes one entry, in first-in first-out order.
- R3: A bus read of the data register returns the oldest receive sample on bus_rdata one cycle later and removes it. A read of an empty receive queue returns 0 and leaves the level at 0.
- R4: The level register (index 1) gives the transmit level in bits 5:0 and the receive level in bits 21:16. A push into a full queue (32 entries) is dropped, and the level stays at 32.
- R5: Writing the control word (index 0) with bit 0 set empties the transmit queue, and with bit 1 set empties the receive queue, both by the next cycle. These bits always read back as 0, and the other fields written with them take effect.
- R6: tx_dreq is high exactly when control bit 4 is 1 and the transmit level is at or below the threshold in control bits 12:8.
- R7: rx_dreq is high exactly when control bit 5 is 1 and the receive level is at or above the threshold in control bits 20:16.
- R8: Writing zero to the control word clears both enables and both thresholds, so the control word reads 0 and both request lines stay low.
- R9: ser_tx_pop on an empty transmit queue returns 0 on ser_tx_data and sets interrupt bit 0. ser_rx_push into a full receive queue drops the sample and sets interrupt bit 1. Both bits stay set until cleared.
- R10: Writing the interrupt status register (index 2) clears each bit written as 1 and leaves bits written as 0 unchanged. A set event in the same cycle as its clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register index: 0 control, 1 level, 2 interrupt status, 3 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ser_tx_pop | input | 1 | Serializer takes one transmit sample |
| ser_tx_data | output | DW | Oldest transmit sample, 0 when empty |
| ser_rx_push | input | 1 | Deserializer delivers one receive sample |
| ser_rx_data | input | DW | Receive sample |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
The bench fills both queues past capacity. A design that let the pointers wrap would lose the oldest sample or report a level of 0 instead of 32. It reads and pops empty queues, where a wrong design would return stale data or drift the level below zero. It also sets an underflow in the same cycle as a clear of that bit, so a design that let the clear win would lose the event. The request lines are stepped through the exact levels on either side of each threshold to catch off-by-one compares, and a combined flush-and-configure write must both empty the queue and keep the new fields.

// File: rtl/asf_pkg.sv
package asf_pkg;
  localparam int BUS_W       = 32;
  localparam int THR_W       = 5;
  localparam int BIT_TX_FLSH = 0;
  localparam int BIT_RX_FLSH = 1;
  localparam int BIT_TX_DMA  = 4;
  localparam int BIT_RX_DMA  = 5;
  localparam int TX_THR_LSB  = 8;
  localparam int RX_THR_LSB  = 16;
  localparam int RX_LVL_LSB  = 16;
  localparam logic [THR_W-1:0] THR_RESET = 5'd16;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_LEVEL = 2'd1,
    SEL_IRQ   = 2'd2,
    SEL_DATA  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;
endpackage

// File: rtl/asf_ring.sv
module asf_ring #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            push,
  input  logic [DW-1:0]   wdata,
  input  logic            pop,
  output logic [DW-1:0]   head,
  output logic [LVLW-1:0] level,
  output logic            full,
  output logic            empty
);
  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]   rd_ptr_q, rd_ptr_d;
  logic [LVLW-1:0] cnt_q, cnt_d;
  logic            push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == LVLW'(DEPTH));
  assign level   = cnt_q;
  assign head    = mem[rd_ptr_q];
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = wr_ptr_q + AW'(1);
      if (pop_ok)  rd_ptr_d = rd_ptr_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + LVLW'(1);
        2'b01:   cnt_d = cnt_q - LVLW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata;
  end

  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LVLW'(DEPTH));
  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/asf_dreq.sv
module asf_dreq #(
  parameter int           LVLW = 6,
  parameter int           THRW = 5,
  parameter asf_pkg::dir_e DIR = asf_pkg::DIR_TX
) (
  input  logic            en,
  input  logic [LVLW-1:0] level,
  input  logic [THRW-1:0] thr,
  output logic            req
);
  localparam int CW = (LVLW > THRW) ? LVLW : THRW;
  logic [CW-1:0] lvl_x, thr_x;
  logic          hit;

  assign lvl_x = CW'(level);
  assign thr_x = CW'(thr);

  generate
    if (DIR == asf_pkg::DIR_TX) begin : g_room
      assign hit = (lvl_x <= thr_x);
    end else begin : g_fill
      assign hit = (lvl_x >= thr_x);
    end
  endgenerate

  assign req = en && hit;
endmodule

// File: rtl/asf_regs.sv
module asf_regs
  import asf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LVLW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [LVLW-1:0]  tx_level,
  input  logic [LVLW-1:0]  rx_level,
  input  logic [DW-1:0]    rx_head,
  input  logic             rx_empty,
  input  logic             tx_unf,
  input  logic             rx_ovf,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic             tx_en,
  output logic             rx_en,
  output logic [THR_W-1:0] tx_thr,
  output logic [THR_W-1:0] rx_thr
);
  logic             ctrl_we, irq_we;
  logic             tx_en_q, tx_en_d, rx_en_q, rx_en_d;
  logic [THR_W-1:0] tx_thr_q, tx_thr_d, rx_thr_q, rx_thr_d;
  logic [1:0]       irq_q, irq_d, irq_clr, irq_set;
  logic [BUS_W-1:0] rd_mux, rdata_q;

  assign ctrl_we  = bus_wr && (bus_addr == SEL_CTRL);
  assign irq_we   = bus_wr && (bus_addr == SEL_IRQ);
  assign tx_flush = ctrl_we && bus_wdata[BIT_TX_FLSH];
  assign rx_flush = ctrl_we && bus_wdata[BIT_RX_FLSH];
  assign irq_clr  = irq_we ? bus_wdata[1:0] : 2'b00;
  assign irq_set  = {rx_ovf, tx_unf};

  always_comb begin
    tx_en_d  = tx_en_q;
    rx_en_d  = rx_en_q;
    tx_thr_d = tx_thr_q;
    rx_thr_d = rx_thr_q;
    if (ctrl_we) begin
      tx_en_d  = bus_wdata[BIT_TX_DMA];
      rx_en_d  = bus_wdata[BIT_RX_DMA];
      tx_thr_d = bus_wdata[TX_THR_LSB +: THR_W];
      rx_thr_d = bus_wdata[RX_THR_LSB +: THR_W];
    end
    irq_d = (irq_q & ~irq_clr) | irq_set;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      SEL_CTRL: begin
        rd_mux[BIT_TX_DMA]              = tx_en_q;
        rd_mux[BIT_RX_DMA]              = rx_en_q;
        rd_mux[TX_THR_LSB +: THR_W]     = tx_thr_q;
        rd_mux[RX_THR_LSB +: THR_W]     = rx_thr_q;
      end
      SEL_LEVEL: begin
        rd_mux[0 +: LVLW]               = tx_level;
        rd_mux[RX_LVL_LSB +: LVLW]      = rx_level;
      end
      SEL_IRQ: rd_mux[1:0] = irq_q;
      default: if (!rx_empty) rd_mux[DW-1:0] = rx_head;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      tx_thr_q <= THR_RESET;
      rx_thr_q <= THR_RESET;
      irq_q    <= 2'b00;
      rdata_q  <= '0;
    end else begin
      tx_en_q  <= tx_en_d;
      rx_en_q  <= rx_en_d;
      tx_thr_q <= tx_thr_d;
      rx_thr_q <= rx_thr_d;
      irq_q    <= irq_d;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign tx_en     = tx_en_q;
  assign rx_en     = rx_en_q;
  assign tx_thr    = tx_thr_q;
  assign rx_thr    = rx_thr_q;

  p_irq_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_unf |=> irq_q[0]);
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q[1] && !irq_clr[1]) |=> irq_q[1]);
  p_zero_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && bus_wdata == '0) |=> (!tx_en_q && !rx_en_q && tx_thr_q == '0 && rx_thr_q == '0));
endmodule

// File: rtl/audio_smpl_fifo.sv
module audio_smpl_fifo
  import asf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ser_tx_pop,
  output logic [DW-1:0]    ser_tx_data,
  input  logic             ser_rx_push,
  input  logic [DW-1:0]    ser_rx_data,
  output logic             tx_dreq,
  output logic             rx_dreq
);
  localparam int LVLW = $clog2(DEPTH + 1);

  logic             rst_s0, rst_q_n;
  logic             tx_flush, rx_flush, tx_en, rx_en;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [LVLW-1:0]  tx_level, rx_level;
  logic [DW-1:0]    tx_head, rx_head;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_push, rx_pop, tx_unf, rx_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_q_n <= rst_s0;
    end
  end

  assign tx_push     = bus_wr && (bus_addr == SEL_DATA);
  assign rx_pop      = bus_rd && (bus_addr == SEL_DATA);
  assign tx_unf      = ser_tx_pop && tx_empty;
  assign rx_ovf      = ser_rx_push && rx_full;
  assign ser_tx_data = tx_empty ? '0 : tx_head;

  asf_regs #(.DW(DW), .LVLW(LVLW)) u_regs (
    .clk(clk), .rst_n(rst_q_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_level(tx_level), .rx_level(rx_level),
    .rx_head(rx_head), .rx_empty(rx_empty),
    .tx_unf(tx_unf), .rx_ovf(rx_ovf),
    .tx_flush(tx_flush), .rx_flush(rx_flush),
    .tx_en(tx_en), .rx_en(rx_en), .tx_thr(tx_thr), .rx_thr(rx_thr)
  );

  asf_ring #(.DW(DW), .DEPTH(DEPTH)) u_tx_ring (
    .clk(clk), .rst_n(rst_q_n), .flush(tx_flush),
    .push(tx_push), .wdata(bus_wdata[DW-1:0]), .pop(ser_tx_pop),
    .head(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  asf_ring #(.DW(DW), .DEPTH(DEPTH)) u_rx_ring (
    .clk(clk), .rst_n(rst_q_n), .flush(rx_flush),
    .push(ser_rx_push), .wdata(ser_rx_data), .pop(rx_pop),
    .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  asf_dreq #(.LVLW(LVLW), .THRW(THR_W), .DIR(DIR_TX)) u_tx_dreq (
    .en(tx_en), .level(tx_level), .thr(tx_thr), .req(tx_dreq)
  );

  asf_dreq #(.LVLW(LVLW), .THRW(THR_W), .DIR(DIR_RX)) u_rx_dreq (
    .en(rx_en), .level(rx_level), .thr(rx_thr), .req(rx_dreq)
  );

  p_empty_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rx_pop && rx_empty) |=> (bus_rdata == '0));
  p_tx_req_off_full_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tx_full && !(tx_thr == THR_W'(DEPTH))) |-> !tx_dreq);
  p_rx_req_on_full_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rx_full && rx_en) |-> rx_dreq);
endmodule

// File: tb/audio_smpl_fifo_test.sv
module audio_smpl_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_tx_pop = 1'b0, ser_rx_push = 1'b0;
  logic [31:0] ser_tx_data;
  logic [31:0] ser_rx_data = '0;
  logic        tx_dreq, rx_dreq;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  audio_smpl_fifo uut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tx_take(output logic [31:0] d);
    @(negedge clk);
    d = ser_tx_data;
    ser_tx_pop = 1'b1;
    @(negedge clk);
    ser_tx_pop = 1'b0;
  endtask

  task automatic rx_give(input logic [31:0] d);
    @(negedge clk);
    ser_rx_push = 1'b1; ser_rx_data = d;
    @(negedge clk);
    ser_rx_push = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk("R1 ctrl after reset", v, 32'h0010_1000);
    rd(2'd1, v); chk("R1 level after reset", v, 32'h0);
    rd(2'd2, v); chk("R1 irq after reset", v, 32'h0);
    chk("R1 dreqs after reset", {30'd0, rx_dreq, tx_dreq}, 32'h0);
  endtask

  task automatic t_tx_order;
    logic [31:0] v;
    for (int i = 0; i < 5; i++) wr(2'd3, 32'hA000_0000 + i);
    rd(2'd1, v); chk("R4 tx level 5", v, 32'd5);
    for (int i = 0; i < 5; i++) begin
      tx_take(v); chk("R2 tx fifo order", v, 32'hA000_0000 + i);
    end
    rd(2'd1, v); chk("R2 tx drained", v, 32'd0);
  endtask

  task automatic t_tx_underflow;
    logic [31:0] v;
    tx_take(v); chk("R9 underflow data zero", v, 32'h0);
    rd(2'd2, v); chk("R9 underflow flag", v, 32'd1);
    wr(2'd2, 32'd0);
    rd(2'd2, v); chk("R10 write zero keeps flag", v, 32'd1);
    wr(2'd2, 32'd1);
    rd(2'd2, v); chk("R10 write one clears flag", v, 32'd0);
  endtask

  task automatic t_rx_path;
    logic [31:0] v;
    for (int i = 0; i < 3; i++) rx_give(32'h5500_0010 + i);
    rd(2'd1, v); chk("R4 rx level 3", v, 32'h0003_0000);
    for (int i = 0; i < 3; i++) begin
      rd(2'd3, v); chk("R3 rx read order", v, 32'h5500_0010 + i);
    end
    rd(2'd3, v); chk("R3 empty read zero", v, 32'h0);
    rd(2'd1, v); chk("R3 empty read keeps level", v, 32'h0);
  endtask

  task automatic t_rx_overflow;
    logic [31:0] v;
    for (int i = 0; i < 33; i++) rx_give(32'h100 + i);
    rd(2'd1, v); chk("R4 rx level capped", v, 32'h0020_0000);
    rd(2'd2, v); chk("R9 overflow flag", v, 32'd2);
    rd(2'd3, v); chk("R9 oldest kept", v, 32'h100);
    rd(2'd1, v); chk("R3 rx level after pop", v, 32'h001F_0000);
    wr(2'd0, 32'h0010_1002);
    rd(2'd1, v); chk("R5 rx flush", v, 32'h0);
    rd(2'd0, v); chk("R5 flush bit reads zero", v, 32'h0010_1000);
    rd(2'd2, v); chk("R9 overflow sticky", v, 32'd2);
    wr(2'd2, 32'd3);
  endtask

  task automatic t_tx_full;
    logic [31:0] v;
    for (int i = 0; i < 33; i++) wr(2'd3, 32'h200 + i);
    rd(2'd1, v); chk("R4 tx level capped", v, 32'd32);
    tx_take(v); chk("R4 tx head after overfill", v, 32'h200);
    wr(2'd0, 32'h0010_1001);
    rd(2'd1, v); chk("R5 tx flush", v, 32'h0);
  endtask

  task automatic t_dreq;
    logic [31:0] v;
    wr(2'd0, 32'h0003_0230);
    rd(2'd0, v); chk("R6 ctrl fields", v, 32'h0003_0230);
    chk("R6 tx req at level 0", {31'd0, tx_dreq}, 32'd1);
    chk("R7 rx req at level 0", {31'd0, rx_dreq}, 32'd0);
    wr(2'd3, 32'h1); wr(2'd3, 32'h2);
    chk("R6 tx req at level equal", {31'd0, tx_dreq}, 32'd1);
    wr(2'd3, 32'h3);
    chk("R6 tx req above threshold", {31'd0, tx_dreq}, 32'd0);
    tx_take(v);
    chk("R6 tx req back at threshold", {31'd0, tx_dreq}, 32'd1);
    rx_give(32'h7); rx_give(32'h8);
    chk("R7 rx req below threshold", {31'd0, rx_dreq}, 32'd0);
    rx_give(32'h9);
    chk("R7 rx req at threshold", {31'd0, rx_dreq}, 32'd1);
    rd(2'd3, v);
    chk("R7 rx req after read", {31'd0, rx_dreq}, 32'd0);
    wr(2'd0, 32'h0003_0233);
    rd(2'd1, v); chk("R5 flush both", v, 32'h0);
    rd(2'd0, v); chk("R5 fields kept with flush", v, 32'h0003_0230);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'd1; ser_tx_pop = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ser_tx_pop = 1'b0;
    rd(2'd2, v); chk("R10 set beats clear", v, 32'd1);
    wr(2'd2, 32'd1);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R8 ctrl zero", v, 32'h0);
    chk("R8 dreqs low", {30'd0, rx_dreq, tx_dreq}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_tx_order();
    t_tx_underflow();
    t_rx_path();
    t_rx_overflow();
    t_tx_full();
    t_dreq();
    t_collide();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule